// File: doc/BRIEF.md
# Lock-gated GPIO pad mode controller

This block controls up to 32 general-purpose pads behind a word-wide register bus. Each pin has one output data bit and two mode bits. The two mode bits choose whether the pad floats, drives fully, pulls only low or pulls only high. The controller turns them, together with the data bit, into a per-pad output enable and output value. Pad inputs pass through a two-flop synchronizer into a readable data-in register.

Firmware can set or clear data bits at any time. The mode bits are protected. A write to them lands only while a key-protected lock register is active. Software arms the lock with a fixed 16-bit key, changes the pin directions and then drops the lock again. A stray write therefore cannot turn an input into a driver.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every register reads 0. All pads are undriven (`pad_oe` = 0), and the lock status at 0x00 reads 0.
- R2: With {mode1,mode0} = 00 the pad is not driven (`pad_oe`=0) for either data value.
- R3: With {mode1,mode0} = 01 the pad is driven (`pad_oe`=1) and `pad_out` equals the data bit.
- R4: With {mode1,mode0} = 10 the pad is driven low when data is 0 and is not driven when data is 1.
- R5: With {mode1,mode0} = 11 the pad is not driven when data is 0 and is driven high when data is 1.
- R6: A write to 0x14 sets the data bits written as 1, and a write to 0x18 clears them. Bits written as 0 keep their value. Neither write depends on the lock.
- R7: The lock lives at offset 0x00. A write whose bits [15:0] equal 0xd42f activates it, whatever bits [31:16] hold. A write of any other value, 0 included, deactivates it. A read of 0x00 returns the status in bit 31, with all other bits 0.
- R8: While the lock is inactive, writes to mode1 (0x08), mode0 (0x0c), mode1-clear (0x50), mode0-set (0x54) and mode0-clear (0x58) are ignored. Reads of 0x08 and 0x0c show the old values.
- R9: While the lock is active, 0x08 and 0x0c replace the whole register. 0x54 sets the mode0 bits written as 1. 0x50 and 0x58 clear the mode1 and mode0 bits written as 1. Reads of 0x08 and 0x0c return mode1 and mode0.
- R10: A read of 0x04 returns the pad inputs. These pass through a two-flop synchronizer and then the data-in register. A change driven before a clock edge becomes visible after the third rising edge and not after the second.
- R11: The pin count NUM_PINS is a parameter of at most 32. With 6 pins, register bits 31..6 read 0 and only six pads exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PINS | Pad input levels, asynchronous |
| pad_oe | output | NUM_PINS | Per-pad output enable |
| pad_out | output | NUM_PINS | Per-pad output value |

## Verification
The bus accepts only one write per cycle, but the input synchronizer advances on every edge. A data-set write that reshapes the pad drive can therefore land on the same edge at which a new pad input level enters the synchronizer. The bench drives both on the same clock. It then checks that the output pads follow the data write after one edge, while the data-in register holds its old value after one and two edges and shows the new level only after the third. A second case puts a lock change on the edge just before a mode write. It checks that a mode write directly after arming lands and one directly after release does not.

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int          NUM_PINS   = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] UNLOCK_KEY = 16'hd42f
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);

  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_M1    = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_M0    = ADDR_W'('h0c);
  localparam logic [ADDR_W-1:0] A_DSET  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_DCLR  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_M1CLR = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] A_M0SET = ADDR_W'('h54);
  localparam logic [ADDR_W-1:0] A_M0CLR = ADDR_W'('h58);

  logic                unlocked;
  logic [NUM_PINS-1:0] mode0, mode1, dout;
  logic [NUM_PINS-1:0] sync1, sync2, din;
  logic [NUM_PINS-1:0] wv;

  assign wv = bus_wdata[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      mode0    <= '0;
      mode1    <= '0;
      dout     <= '0;
      sync1    <= '0;
      sync2    <= '0;
      din      <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      din   <= sync2;
      if (bus_wr) begin
        case (bus_addr)
          A_LOCK:  unlocked <= (bus_wdata[15:0] == UNLOCK_KEY);
          A_DSET:  dout <= dout | wv;
          A_DCLR:  dout <= dout & ~wv;
          A_M1:    if (unlocked) mode1 <= wv;
          A_M0:    if (unlocked) mode0 <= wv;
          A_M1CLR: if (unlocked) mode1 <= mode1 & ~wv;
          A_M0SET: if (unlocked) mode0 <= mode0 | wv;
          A_M0CLR: if (unlocked) mode0 <= mode0 & ~wv;
          default: ;
        endcase
      end
    end
  end

  // 01 push-pull, 10 drive only low, 11 drive only high, 00 float
  assign pad_oe  = (mode0 & ~mode1) | (mode1 & ~(mode0 ^ dout));
  assign pad_out = pad_oe & dout;

  always_comb begin
    case (bus_addr)
      A_LOCK:  bus_rdata = {unlocked, 31'b0};
      A_DIN:   bus_rdata = 32'(din);
      A_M1:    bus_rdata = 32'(mode1);
      A_M0:    bus_rdata = 32'(mode0);
      default: bus_rdata = 32'b0;
    endcase
  end

endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int          NUM_PINS   = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] UNLOCK_KEY = 16'hd42f
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic                unlocked,
  input logic [NUM_PINS-1:0] mode0,
  input logic [NUM_PINS-1:0] mode1,
  input logic [NUM_PINS-1:0] dout,
  input logic [NUM_PINS-1:0] pad_out
);

  localparam logic [ADDR_W-1:0] C_LOCK = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] C_DSET = ADDR_W'('h14);

  assert_key_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_LOCK && bus_wdata[15:0] == UNLOCK_KEY) |=> unlocked);

  assert_other_value_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_LOCK && bus_wdata[15:0] != UNLOCK_KEY) |=> !unlocked);

  assert_modes_frozen_when_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(mode0) && $stable(mode1)));

  assert_set_reaches_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_DSET) |=>
      ((dout & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

  assert_no_high_without_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~dout) == '0);

endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .unlocked(unlocked), .mode0(mode0),
  .mode1(mode1), .dout(dout), .pad_out(pad_out)
);

// File: tb/gpio_pad_ctrl_test.sv
module gpio_pad_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata6;
  logic [31:0] pad_in = '0, pad_oe, pad_out;
  logic [5:0]  pad_in6 = '0, pad_oe6, pad_out6;
  int nchecks = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_pad_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out));

  gpio_pad_ctrl #(.NUM_PINS(6)) uut6 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata6), .pad_in(pad_in6),
    .pad_oe(pad_oe6), .pad_out(pad_out6));

  // entries: {mode1, mode0, data, expected oe, expected out}
  localparam logic [4:0] VEC [8] = '{
    5'b00000, 5'b00100, 5'b01010, 5'b01111,
    5'b10010, 5'b10100, 5'b11000, 5'b11111 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #500us;
    if (!done) begin
      nchecks++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    rd(8'h00, r); chk("R1 lock", r, 32'h0);
    rd(8'h0c, r); chk("R1 mode0", r, 32'h0);
    rd(8'h08, r); chk("R1 mode1", r, 32'h0);

    // R2..R5 decode table
    wr(8'h00, 32'h0000d42f);
    for (int i = 0; i < 8; i++) begin
      wr(8'h08, {32{VEC[i][4]}});
      wr(8'h0c, {32{VEC[i][3]}});
      if (VEC[i][2]) wr(8'h14, 32'hffffffff); else wr(8'h18, 32'hffffffff);
      chk({mode_req(VEC[i][4:3]), " oe"}, pad_oe, {32{VEC[i][1]}});
      chk({mode_req(VEC[i][4:3]), " out"}, pad_out, {32{VEC[i][0]}});
    end

    // R7 lock key handling
    wr(8'h00, 32'h1234d42f); rd(8'h00, r); chk("R7 key with upper bits", r, 32'h80000000);
    wr(8'h00, 32'h0000d42e); rd(8'h00, r); chk("R7 wrong key", r, 32'h0);
    wr(8'h00, 32'h0000d42f); wr(8'h00, 32'h0); rd(8'h00, r); chk("R7 release", r, 32'h0);

    // R8 mode writes ignored while locked (mode1=ffffffff, mode0=ffffffff here)
    wr(8'h0c, 32'h0); wr(8'h58, 32'h0000ffff); wr(8'h50, 32'hffff0000);
    rd(8'h0c, r); chk("R8 mode0", r, 32'hffffffff);
    rd(8'h08, r); chk("R8 mode1", r, 32'hffffffff);
    chk("R8 pads unchanged", pad_oe, 32'hffffffff);

    // R9 set/clear under lock
    wr(8'h00, 32'h0000d42f);
    wr(8'h0c, 32'h000000f0); wr(8'h54, 32'h0000000f);
    rd(8'h0c, r); chk("R9 mode0 set", r, 32'h000000ff);
    wr(8'h58, 32'h0000003c); rd(8'h0c, r); chk("R9 mode0 clear", r, 32'h000000c3);
    wr(8'h08, 32'h000000aa); wr(8'h50, 32'h0000000a);
    rd(8'h08, r); chk("R9 mode1 clear", r, 32'h000000a0);

    // R6 data set/clear in push-pull mode
    wr(8'h08, 32'h0); wr(8'h0c, 32'hffffffff); wr(8'h00, 32'h0);
    wr(8'h18, 32'hffffffff);
    wr(8'h14, 32'h5); wr(8'h14, 32'h8); chk("R6 set", pad_out, 32'hd);
    wr(8'h18, 32'h4); chk("R6 clear", pad_out, 32'h9);

    // R10 sync latency, coinciding with a data-set write
    @(negedge clk);
    pad_in = 32'ha5a50001; bus_addr = 8'h14; bus_wdata = 32'h00000030; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R6 set beside input edge", pad_out, 32'h39);
    rd(8'h04, r); chk("R10 after one edge", r, 32'h0);
    @(negedge clk); rd(8'h04, r); chk("R10 after two edges", r, 32'h0);
    @(negedge clk); rd(8'h04, r); chk("R10 after three edges", r, 32'ha5a50001);

    // lock change on the edge before a mode write
    wr(8'h00, 32'h0000d42f); wr(8'h0c, 32'h0000000f);
    rd(8'h0c, r); chk("R9 write right after arming", r, 32'h0000000f);
    wr(8'h00, 32'h0); wr(8'h0c, 32'h000000f0);
    rd(8'h0c, r); chk("R8 write right after release", r, 32'h0000000f);

    // R11 six-pin instance
    pad_in6 = 6'h3f;
    wr(8'h00, 32'h0000d42f); wr(8'h0c, 32'hffffffff);
    bus_addr = 8'h0c; #1 chk("R11 mode0 width", rdata6, 32'h0000003f);
    repeat (3) @(negedge clk);
    bus_addr = 8'h04; #1 chk("R11 data-in width", rdata6, 32'h0000003f);
    chk("R11 pad_oe", {26'b0, pad_oe6}, 32'h0000003f);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule